// File: doc/BRIEF.md
# Vector Type Decoder with Maximum Length

This block decodes the 8-bit vector-type field of a vector-configure instruction. It reports the element width, the register-group multiplier, the two policy flags and the largest element count that a register group can hold. It also works out the vector length granted for a requested application vector length. The caller passes the low byte of either immediate form, the 11-bit one from the register form or the 10-bit one from the all-immediate form, because only that byte carries fields. The caller also passes the requested length. The result is held in an output register until the consumer takes it.

The multiplier is a signed 3-bit code. Positive codes scale the per-register element count up by 1, 2, 4 or 8. Negative codes scale it down by 2, 4 or 8. Code 100 is reserved. A reserved width code, or a width above the `ELEN` parameter, marks the configuration illegal. An illegal configuration zeroes every decoded field and both lengths, and raises the illegal flag.

Top module: `vtype_cfg_unit`

## Requirements
- R1: For a legal configuration, `outSewBits` equals 8 << imm[5:3], giving 8, 16, 32 or 64.
- R2: For multiplier codes imm[2:0] = 0..3, `outVlmax` = (VLEN / SEW) << code, and `outLmulCode` echoes the code.
- R3: For multiplier codes 7, 6 and 5, `outVlmax` = (VLEN / SEW) divided by 2, 4 and 8 respectively.
- R4: Multiplier code 100 raises `outIllegal`.
- R5: A width code imm[5:3] of 4 or more, or a width larger than ELEN, raises `outIllegal`.
- R6: When `outIllegal` is 1, `outVlmax`, `outVl`, `outSewBits`, `outLmulCode`, `outTailAgn` and `outMaskAgn` are all 0.
- R7: For a legal configuration, `outTailAgn` follows imm[6] and `outMaskAgn` follows imm[7] (1 = agnostic, 0 = undisturbed).
- R8: For a legal configuration, `outVl` = min(`avl`, `outVlmax`).
- R9: A request is taken on a clock edge where `inValid` and `inReady` are both 1. `outValid` is 1 in the following cycle. `inReady` = !`outValid` || `outReady`. A result stays valid and unchanged while `outReady` is 0.
- R10: While `rstN` is low, `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| vtypeImm | input | 8 | Low byte of the configure immediate |
| avl | input | AVL_W | Requested application vector length |
| outValid | output | 1 | Decoded result present |
| outReady | input | 1 | Consumer takes the result |
| outSewBits | output | 7 | Element width in bits |
| outLmulCode | output | 3 | Multiplier code (bit 2 set = fractional) |
| outTailAgn | output | 1 | Tail-agnostic flag |
| outMaskAgn | output | 1 | Mask-agnostic flag |
| outIllegal | output | 1 | Illegal configuration |
| outVlmax | output | VL_W | Maximum vector length |
| outVl | output | VL_W | Granted vector length |

## Verification
The assertions assume that `inValid` and `outReady` are driven to known levels from reset onward. They also assume that the request fields are ignored whenever `inValid` is low, so nothing is asserted about `vtypeImm` or `avl` outside an accepted request. The stimulus drives every input to a defined value at reset and changes inputs only just after a rising edge. It sweeps every width and multiplier code, including the reserved ones. It also applies random consumer stalls, so that results are held across several cycles while new requests wait.

// File: rtl/vtype_pkg.sv
package vtype_pkg;

  typedef struct packed {
    logic load;  // capture a new decoded result
    logic drop;  // result consumed, nothing replaces it
  } vtype_strb_t;

  typedef struct packed {
    logic [6:0] sewBits;
    logic [2:0] lmulCode;
    logic       tailAgn;
    logic       maskAgn;
    logic       illegal;
  } vtype_fields_t;

endpackage

// File: rtl/vtype_ctrl.sv
module vtype_ctrl
  import vtype_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output vtype_strb_t strb
);

  logic validQ;

  assign inReady   = !validQ || outReady;
  assign strb.load = inValid && inReady;
  assign strb.drop = validQ && outReady && !inValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strb.load) begin
      validQ <= 1'b1;
    end else if (strb.drop) begin
      validQ <= 1'b0;
    end
  end

  assign outValid = validQ;

endmodule

// File: rtl/vtype_dp.sv
module vtype_dp
  import vtype_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int ELEN  = 64,
  parameter int AVL_W = 16,
  parameter int VL_W  = $clog2(VLEN) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  vtype_strb_t       strb,
  input  logic [7:0]        vtypeImm,
  input  logic [AVL_W-1:0]  avl,
  output vtype_fields_t     fields,
  output logic [VL_W-1:0]   vlmax,
  output logic [VL_W-1:0]   vl
);

  localparam int CMP_W = (AVL_W > VL_W) ? AVL_W : VL_W;

  logic [2:0]      sewCode;
  logic [2:0]      lmulCode;
  logic            sewLegal;
  logic            lmulLegal;
  logic            illegalC;
  logic [VL_W-1:0] elemsTab [4];
  logic [VL_W-1:0] elemsPerReg;
  logic [1:0]      shrAmt;
  logic [VL_W-1:0] groupC;
  logic [CMP_W-1:0] avlExt;
  logic [CMP_W-1:0] groupExt;
  logic [VL_W-1:0] vlC;
  vtype_fields_t   fieldsC;

  // element count of one register for each legal width code
  for (genvar g = 0; g < 4; g++) begin : g_elems
    assign elemsTab[g] = VL_W'(VLEN >> (g + 3));
  end

  assign sewCode   = vtypeImm[5:3];
  assign lmulCode  = vtypeImm[2:0];
  assign sewLegal  = !sewCode[2] && ((32'd8 << sewCode[1:0]) <= ELEN);
  assign lmulLegal = (lmulCode != 3'b100);
  assign illegalC  = !sewLegal || !lmulLegal;

  assign elemsPerReg = elemsTab[sewCode[1:0]];
  assign shrAmt      = 2'(3'd4 - {1'b0, lmulCode[1:0]});

  always_comb begin
    if (illegalC) begin
      groupC = '0;
    end else if (lmulCode[2]) begin
      groupC = elemsPerReg >> shrAmt;
    end else begin
      groupC = elemsPerReg << lmulCode[1:0];
    end
  end

  assign avlExt   = CMP_W'(avl);
  assign groupExt = CMP_W'(groupC);
  assign vlC      = (avlExt < groupExt) ? VL_W'(avlExt) : groupC;

  always_comb begin
    fieldsC = '0;
    fieldsC.illegal = illegalC;
    if (!illegalC) begin
      fieldsC.sewBits  = 7'd8 << sewCode[1:0];
      fieldsC.lmulCode = lmulCode;
      fieldsC.tailAgn  = vtypeImm[6];
      fieldsC.maskAgn  = vtypeImm[7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fields <= '0;
      vlmax  <= '0;
      vl     <= '0;
    end else if (strb.load) begin
      fields <= fieldsC;
      vlmax  <= groupC;
      vl     <= vlC;
    end
  end

endmodule

// File: rtl/vtype_cfg_unit.sv
module vtype_cfg_unit
  import vtype_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int ELEN  = 64,
  parameter int AVL_W = 16,
  parameter int VL_W  = $clog2(VLEN) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [7:0]       vtypeImm,
  input  logic [AVL_W-1:0] avl,
  output logic             outValid,
  input  logic             outReady,
  output logic [6:0]       outSewBits,
  output logic [2:0]       outLmulCode,
  output logic             outTailAgn,
  output logic             outMaskAgn,
  output logic             outIllegal,
  output logic [VL_W-1:0]  outVlmax,
  output logic [VL_W-1:0]  outVl
);

  vtype_strb_t   strb;
  vtype_fields_t fields;

  vtype_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  vtype_dp #(
    .VLEN (VLEN),
    .ELEN (ELEN),
    .AVL_W(AVL_W),
    .VL_W (VL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .vtypeImm (vtypeImm),
    .avl      (avl),
    .fields   (fields),
    .vlmax    (outVlmax),
    .vl       (outVl)
  );

  assign outSewBits  = fields.sewBits;
  assign outLmulCode = fields.lmulCode;
  assign outTailAgn  = fields.tailAgn;
  assign outMaskAgn  = fields.maskAgn;
  assign outIllegal  = fields.illegal;

endmodule

// File: rtl/vtype_chk.sv
module vtype_chk #(
  parameter int VLEN  = 128,
  parameter int ELEN  = 64,
  parameter int VL_W  = $clog2(VLEN) + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            inReady,
  input logic            outValid,
  input logic            outReady,
  input logic [6:0]      outSewBits,
  input logic [2:0]      outLmulCode,
  input logic            outTailAgn,
  input logic            outMaskAgn,
  input logic            outIllegal,
  input logic [VL_W-1:0] outVlmax,
  input logic [VL_W-1:0] outVl
);

  p_sew_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIllegal) |-> ($countones(outSewBits) == 1 && outSewBits <= ELEN));

  p_reserved_lmul_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIllegal) |-> (outLmulCode != 3'b100));

  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIllegal) |-> (outVl == '0 && outVlmax == '0 && outSewBits == '0
                                  && !outTailAgn && !outMaskAgn));

  p_vl_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outVl <= outVlmax));

  p_vlmax_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outVlmax <= VLEN));

  p_take_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  p_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outVl) && $stable(outVlmax)
                                 && $stable(outIllegal) && $stable(outSewBits)));

endmodule

bind vtype_cfg_unit vtype_chk #(
  .VLEN(VLEN),
  .ELEN(ELEN),
  .VL_W(VL_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outSewBits (outSewBits),
  .outLmulCode(outLmulCode),
  .outTailAgn (outTailAgn),
  .outMaskAgn (outMaskAgn),
  .outIllegal (outIllegal),
  .outVlmax   (outVlmax),
  .outVl      (outVl)
);

// File: tb/sim_vtype_cfg_unit.sv
`timescale 1ns/1ps
module sim_vtype_cfg_unit;

  localparam int VLEN  = 256;
  localparam int ELEN  = 32;
  localparam int AVL_W = 12;
  localparam int VL_W  = $clog2(VLEN) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic outReady = 1'b1;
  logic [7:0] vtypeImm = '0;
  logic [AVL_W-1:0] avl = '0;
  logic inReady, outValid, outTailAgn, outMaskAgn, outIllegal;
  logic [6:0] outSewBits;
  logic [2:0] outLmulCode;
  logic [VL_W-1:0] outVlmax, outVl;

  always #5 clk = ~clk;

  vtype_cfg_unit #(.VLEN(VLEN), .ELEN(ELEN), .AVL_W(AVL_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .vtypeImm(vtypeImm), .avl(avl), .outValid(outValid), .outReady(outReady),
    .outSewBits(outSewBits), .outLmulCode(outLmulCode), .outTailAgn(outTailAgn),
    .outMaskAgn(outMaskAgn), .outIllegal(outIllegal), .outVlmax(outVlmax), .outVl(outVl)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit mValid = 0;
  int eSew, eLc, eTa, eMa, eVm, eVl, eIll, eRawLc;

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic refDecode(logic [7:0] imm, int req);
    int sc, lc, sew, per;
    sc = int'(imm[5:3]);
    lc = int'(imm[2:0]);
    eRawLc = lc;
    sew = 8 * (2 ** (sc % 4));
    eIll = (sc > 3 || lc == 4 || sew > ELEN) ? 1 : 0;
    if (eIll != 0) begin
      eSew = 0; eLc = 0; eTa = 0; eMa = 0; eVm = 0; eVl = 0;
    end else begin
      per = VLEN / sew;
      if (lc < 4) eVm = per * (2 ** lc);
      else        eVm = per / (2 ** (8 - lc));
      eSew = sew; eLc = lc;
      eTa = int'(imm[6]); eMa = int'(imm[7]);
      eVl = (req < eVm) ? req : eVm;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mValid = 0;
    end else if (inValid && (!mValid || outReady)) begin
      mValid = 1;
      refDecode(vtypeImm, int'(avl));
    end else if (outReady) begin
      mValid = 0;
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      chk(int'(outValid), 0, "R10");
      chk(int'(inReady), 1, "R10");
    end else if (!finished) begin
      chk(int'(outValid), int'(mValid), "R9");
      chk(int'(inReady), (!mValid || outReady) ? 1 : 0, "R9");
      if (mValid) begin
        chk(int'(outIllegal), eIll, (eRawLc == 4) ? "R4" : "R5");
        chk(int'(outSewBits), eSew, (eIll != 0) ? "R6" : "R1");
        chk(int'(outLmulCode), eLc, (eIll != 0) ? "R6" : "R2");
        chk(int'(outTailAgn), eTa, (eIll != 0) ? "R6" : "R7");
        chk(int'(outMaskAgn), eMa, (eIll != 0) ? "R6" : "R7");
        chk(int'(outVlmax), eVm, (eIll != 0) ? "R6" : ((eRawLc > 4) ? "R3" : "R2"));
        chk(int'(outVl), eVl, (eIll != 0) ? "R6" : "R8");
      end
    end
  end

  task automatic send(logic [7:0] imm, int req);
    @(posedge clk); #1;
    inValid = 1'b1; outReady = 1'b1;
    vtypeImm = imm; avl = AVL_W'(req);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // directed: widths, integer and fractional multipliers, reserved codes
    send(8'h00, 4000);  // e8 m1: 32 (R2)
    send(8'h09, 20);    // e16 m2: vlmax 32, vl 20 (R8)
    send(8'h13, 4000);  // e32 m8: 64
    send(8'h07, 9);     // e8 mf2: 16 (R3)
    send(8'h0E, 0);     // e16 mf4: 4, vl 0
    send(8'h15, 5);     // e32 mf8: 1
    send(8'h04, 7);     // reserved multiplier (R4)
    send(8'h18, 7);     // e64 above ELEN (R5)
    send(8'h20, 7);     // reserved width code (R5)
    send(8'hC3, 4095);  // e8 m8 with both agnostic: 256 (R7)
    send(8'h40, 3);
    send(8'h80, 3);
    // stall: hold result while consumer is not ready (R9)
    @(posedge clk); #1;
    inValid = 1'b1; vtypeImm = 8'h0B; avl = 12'd50;
    @(posedge clk); #1;
    outReady = 1'b0; vtypeImm = 8'h00; avl = 12'd1;
    repeat (4) @(posedge clk);
    #1 outReady = 1'b1; inValid = 1'b0;
    // random traffic with back-pressure
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      inValid  = ($urandom % 4) != 0;
      outReady = ($urandom % 3) != 0;
      vtypeImm = 8'($urandom);
      avl      = AVL_W'($urandom % 300);
    end
    @(posedge clk); #1;
    inValid = 1'b0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule